// File: doc/BRIEF.md
# Clock Output Mux-Divider Bank

Four clock output channels, A to D, each take one of four source clocks: the reference clock at index 0 or one of three PLL clocks at indices 1 to 3. The selected clock then passes through an integer post divider. All sources are oversampled on the fast system clock `clk`. A channel's counter advances once per rising edge of its selected source. A configuration bank holds every selector, modulus and power-down bit. It is loaded through a shift-in port.

Channels C and D each hold two complete selector/modulus settings. The live `alt_set_i` pin chooses between them, so the output frequency can change without a reload. A channel adopts a new setting only at its divider's terminal count. Its counter therefore never restarts in the middle of a period.

The power-down pin disables only the blocks whose own bank bit is set. It also drives power-down requests to the PLLs and to the crystal oscillator. The output-enable pin releases the output pads. The pads are modelled as a data bit plus a driver-enable bit. A fully cleared bank passes the reference clock undivided to all four outputs.

Top module: `clk_out_bank`

## Requirements
- R1: Reset clears the whole 67-bit configuration bank. With the bank clear, every `clk_o` bit equals `src_i[0]` in the same cycle.
- R2: While `shift_en_i` is high, each rising edge of `clk` shifts `shift_dat_i` into bank bit 0 and moves every bit up one place, so the first bit sent ends up in bit 66 (MSB first). While `shift_en_i` is low, the bank holds.
- R3: A setting is 10 bits: a 2-bit selector in bits [9:8] and an 8-bit modulus in bits [7:0]. Selector value s routes `src_i[s]` to the channel (0 is the reference).
- R4: A modulus of 0 or 1 passes the selected source through unchanged. A modulus N of 2 or more counts rising edges of the source. The output is high for the first (N+1)/2 source periods of each N-period cycle and low for the rest. This gives a 50% duty cycle for even N and one extra high period for odd N.
- R5: A channel adopts a changed setting (bank write or select-pin change) only at its divider's terminal count. Terminal count is the source rising edge that ends a cycle, and in pass-through mode every rising edge is a terminal count. The counter then restarts at zero.
- R6: Channel C uses bank bits [29:20] while `alt_set_i` is low and bits [49:40] while it is high. Channel D uses bits [39:30] while `alt_set_i` is low and bits [59:50] while it is high.
- R7: Channels A (bits [9:0]) and B (bits [19:10]) ignore `alt_set_i`.
- R8: When `pwr_dn_i` is high and divider power-down bit 60+k is set, channel k outputs 0 and its counter is held at zero. Channels whose bit is clear keep running.
- R9: `pll_pd_o[i]` equals `pwr_dn_i` AND bank bit 64+i.
- R10: `osc_pd_o` is high exactly when `pwr_dn_i` is high and bank bits [66:60] are all set.
- R11: When `out_en_i` is low, `clk_oe_o` is all zero and `clk_o` is all zero, so every pad is high-impedance. When `out_en_i` is high, `clk_oe_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 4 | Source clocks: [0] reference, [3:1] PLL outputs |
| shift_en_i | input | 1 | Configuration shift enable |
| shift_dat_i | input | 1 | Configuration serial data, MSB first |
| alt_set_i | input | 1 | Selects the second setting for channels C and D |
| pwr_dn_i | input | 1 | Power-down request for blocks with their bit set |
| out_en_i | input | 1 | Output pad enable |
| clk_o | output | 4 | Channel clock data, A in bit 0 |
| clk_oe_o | output | 4 | Pad driver enables |
| pll_pd_o | output | 3 | PLL power-down requests |
| osc_pd_o | output | 1 | Oscillator power-down request |

## Verification
Four source clocks with distinct periods (6, 4, 10 and 8 system cycles) mean that a wrong selector index shows up as a wrong output period. Moduli of 0, 1, 2, 3, 4, 5, 6, 7 and 9 separate pass-through from counting, and even duty from odd duty. Toggling the select pin while C and D run with different moduli shows whether the swap waits for the terminal count, while A and B must not react. A power-down pattern that sets every other channel's bit shows which channels stop. A final all-bits pattern drives the oscillator request.

// File: rtl/cob_pkg.sv
package cob_pkg;

    localparam int NCH  = 4;
    localparam int NPLL = 3;
    localparam int NSRC = NPLL + 1;
    localparam int NALT = 2;
    localparam int NSET = NCH + NALT;
    localparam int SELW = $clog2(NSRC);
    localparam int MODW = 8;

    typedef struct packed {
        logic [SELW-1:0] sel;
        logic [MODW-1:0] mod;
    } chset_t;

    localparam int SET_W = $bits(chset_t);

    typedef struct packed {
        logic [NPLL-1:0]         pll_pd;
        logic [NCH-1:0]          div_pd;
        chset_t [NSET-1:0]       sets;
    } bank_t;

    localparam int BANK_W = $bits(bank_t);
    localparam int DIVLO  = NSET * SET_W;

    function automatic logic [MODW-1:0] eff_mod(input logic [MODW-1:0] m);
        return (m < MODW'(2)) ? MODW'(1) : m;
    endfunction

    function automatic logic [MODW:0] high_len(input logic [MODW-1:0] n);
        return ({1'b0, n} + (MODW+1)'(1)) >> 1;
    endfunction

endpackage

// File: rtl/cob_cfg_shift.sv
module cob_cfg_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         dat_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (en_i) begin
            q_o <= {q_o[W-2:0], dat_i};
        end
    end
endmodule

// File: rtl/cob_chan_div.sv
module cob_chan_div
    import cob_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  chset_t          set_pri_i,
    input  chset_t          set_alt_i,
    input  logic            alt_sel_i,
    input  logic            off_i,
    output logic            clk_o
);
    chset_t          act_q;
    chset_t          want;
    logic [NSRC-1:0] prev_q;
    logic [MODW-1:0] cnt_q;
    logic [MODW-1:0] n_eff;
    logic [MODW:0]   hi;
    logic            rise;
    logic            term;

    always_comb begin
        want  = alt_sel_i ? set_alt_i : set_pri_i;
        n_eff = eff_mod(act_q.mod);
        hi    = high_len(n_eff);
        rise  = src_i[act_q.sel] & ~prev_q[act_q.sel];
        term  = rise && (cnt_q >= n_eff - MODW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            cnt_q  <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= src_i;
            if (off_i || term) begin
                cnt_q <= '0;
                act_q <= want;
            end else if (rise) begin
                cnt_q <= cnt_q + MODW'(1);
            end
        end
    end

    always_comb begin
        if (off_i) begin
            clk_o = 1'b0;
        end else if (n_eff == MODW'(1)) begin
            clk_o = src_i[act_q.sel];
        end else begin
            clk_o = ({1'b0, cnt_q} < hi);
        end
    end
endmodule

// File: rtl/clk_out_bank.sv
module clk_out_bank
    import cob_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic            shift_en_i,
    input  logic            shift_dat_i,
    input  logic            alt_set_i,
    input  logic            pwr_dn_i,
    input  logic            out_en_i,
    output logic [NCH-1:0]  clk_o,
    output logic [NCH-1:0]  clk_oe_o,
    output logic [NPLL-1:0] pll_pd_o,
    output logic            osc_pd_o
);
    logic [BANK_W-1:0] bank_raw;
    bank_t             bank_q;
    logic [NCH-1:0]    ch_out;

    cob_cfg_shift #(.W(BANK_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .en_i  (shift_en_i),
        .dat_i (shift_dat_i),
        .q_o   (bank_raw)
    );

    assign bank_q = bank_t'(bank_raw);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        localparam bit ALT  = (k >= NCH - NALT);
        localparam int AIDX = ALT ? k + NALT : k;
        cob_chan_div u_div (
            .clk       (clk),
            .rst       (rst),
            .src_i     (src_i),
            .set_pri_i (bank_q.sets[k]),
            .set_alt_i (bank_q.sets[AIDX]),
            .alt_sel_i (ALT ? alt_set_i : 1'b0),
            .off_i     (pwr_dn_i & bank_q.div_pd[k]),
            .clk_o     (ch_out[k])
        );
    end

    assign clk_o    = out_en_i ? ch_out : '0;
    assign clk_oe_o = {NCH{out_en_i}};
    assign pll_pd_o = pwr_dn_i ? bank_q.pll_pd : '0;
    assign osc_pd_o = pwr_dn_i & (&bank_q.pll_pd) & (&bank_q.div_pd);
endmodule

// File: rtl/clk_out_bank_chk.sv
module clk_out_bank_chk
    import cob_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              shift_en_i,
    input logic              shift_dat_i,
    input logic              pwr_dn_i,
    input logic              out_en_i,
    input logic [BANK_W-1:0] bank_raw,
    input logic [NCH-1:0]    clk_o,
    input logic [NCH-1:0]    clk_oe_o,
    input logic [NPLL-1:0]   pll_pd_o,
    input logic              osc_pd_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (bank_raw == '0));

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
        shift_en_i |=> (bank_raw[0] == $past(shift_dat_i)));

    assert_shift_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_en_i |=> $stable(bank_raw));

    for (genvar k = 0; k < NCH; k++) begin : g_pd
        assert_pd_low_R8: assert property (@(posedge clk) disable iff (rst)
            (out_en_i && pwr_dn_i && bank_raw[DIVLO + k]) |-> !clk_o[k]);
    end

    assert_no_pd_req_R9: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_i |-> ((pll_pd_o == '0) && !osc_pd_o));

    assert_osc_pd_R10: assert property (@(posedge clk) disable iff (rst)
        osc_pd_o |-> ((&pll_pd_o) && pwr_dn_i));

    assert_pads_off_R11: assert property (@(posedge clk) disable iff (rst)
        !out_en_i |-> ((clk_oe_o == '0) && (clk_o == '0)));
endmodule

bind clk_out_bank clk_out_bank_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .shift_en_i  (shift_en_i),
    .shift_dat_i (shift_dat_i),
    .pwr_dn_i    (pwr_dn_i),
    .out_en_i    (out_en_i),
    .bank_raw    (bank_raw),
    .clk_o       (clk_o),
    .clk_oe_o    (clk_oe_o),
    .pll_pd_o    (pll_pd_o),
    .osc_pd_o    (osc_pd_o)
);

// File: tb/clk_out_bank_tb.sv
module clk_out_bank_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] src = 4'b0;
    logic       sh_en = 1'b0, sh_d = 1'b0, alt = 1'b0, pd = 1'b0, oe = 1'b1;
    logic [3:0] clk_o, clk_oe;
    logic [2:0] pll_pd;
    logic       osc_pd;

    int checks = 0, fails = 0, cyc = 0;
    bit chk_on = 1'b0;
    string ph_ab = "R1", ph_cd = "R1";

    // behavioural model state
    logic [66:0] mb = '0;
    int msel[4], mmod[4], mcnt[4];
    logic [3:0] mprev = '0;

    clk_out_bank u_dut (
        .clk(clk), .rst(rst), .src_i(src), .shift_en_i(sh_en), .shift_dat_i(sh_d),
        .alt_set_i(alt), .pwr_dn_i(pd), .out_en_i(oe), .clk_o(clk_o),
        .clk_oe_o(clk_oe), .pll_pd_o(pll_pd), .osc_pd_o(osc_pd)
    );

    always #5 clk = ~clk;

    function automatic int period(int i);
        case (i)
            0: return 6;
            1: return 4;
            2: return 10;
            default: return 8;
        endcase
    endfunction

    always @(posedge clk) begin
        #2;
        cyc++;
        for (int i = 0; i < 4; i++) src[i] = (cyc % period(i)) < (period(i) / 2);
    end

    function automatic int eff(int m);
        return (m < 2) ? 1 : m;
    endfunction

    // model update on each rising edge, using values before the edge
    always @(posedge clk) begin
        if (rst) begin
            mb = '0;
            mprev = '0;
            for (int k = 0; k < 4; k++) begin msel[k] = 0; mmod[k] = 0; mcnt[k] = 0; end
        end else begin
            for (int k = 0; k < 4; k++) begin
                int j, ws, wm;
                j  = (k >= 2 && alt) ? k + 2 : k;
                ws = int'(mb[j*10+8 +: 2]);
                wm = int'(mb[j*10 +: 8]);
                if (pd && mb[60+k]) begin
                    mcnt[k] = 0; msel[k] = ws; mmod[k] = wm;
                end else if (src[msel[k]] && !mprev[msel[k]]) begin
                    if (mcnt[k] >= eff(mmod[k]) - 1) begin
                        mcnt[k] = 0; msel[k] = ws; mmod[k] = wm;
                    end else begin
                        mcnt[k]++;
                    end
                end
            end
            mprev = src;
            if (sh_en) mb = {mb[65:0], sh_d};
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            for (int k = 0; k < 4; k++) begin
                int n, e;
                string tag;
                bit off;
                n   = eff(mmod[k]);
                off = pd && mb[60+k];
                if (!oe) e = 0;
                else if (off) e = 0;
                else if (n == 1) e = int'(src[msel[k]]);
                else e = (mcnt[k] < (n + 1) / 2) ? 1 : 0;
                tag = !oe ? "R11" : off ? "R8" : (k < 2) ? ph_ab : ph_cd;
                chk(tag, $sformatf("clk_o[%0d]", k), int'(clk_o[k]), e);
            end
            chk("R11", "clk_oe_o", int'(clk_oe), oe ? 15 : 0);
            chk("R9", "pll_pd_o", int'(pll_pd), pd ? int'(mb[66:64]) : 0);
            chk("R10", "osc_pd_o", int'(osc_pd), int'(pd && (&mb[66:60])));
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    function automatic logic [66:0] put(logic [66:0] v, int j, int s, int m);
        v[j*10+8 +: 2] = 2'(s);
        v[j*10 +: 8]   = 8'(m);
        return v;
    endfunction

    task automatic load(logic [66:0] v);
        for (int i = 66; i >= 0; i--) begin
            sh_en = 1'b1; sh_d = v[i]; tick(1);
        end
        sh_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [66:0] v;
        tick(3);
        rst = 1'b0;
        chk_on = 1'b1;
        tick(30);                                   // R1 cleared bank passes reference

        v = '0;
        v = put(v, 0, 1, 2);  v = put(v, 1, 2, 3);
        v = put(v, 2, 3, 4);  v = put(v, 3, 0, 1);
        v = put(v, 4, 0, 5);  v = put(v, 5, 1, 0);
        ph_ab = "R2"; ph_cd = "R2";
        load(v);
        ph_ab = "R3 R4"; ph_cd = "R3 R4 R5";
        tick(150);

        ph_ab = "R7"; ph_cd = "R6 R5";
        alt = 1'b1; tick(150);
        alt = 1'b0; tick(23);
        alt = 1'b1; tick(17);
        alt = 1'b0; tick(60);

        v = '0;
        v = put(v, 0, 3, 7);  v = put(v, 1, 0, 6);
        v = put(v, 2, 2, 2);  v = put(v, 3, 1, 9);
        v = put(v, 4, 1, 3);  v = put(v, 5, 2, 0);
        v[63:60] = 4'b0101;  v[66:64] = 3'b010;
        ph_ab = "R2 R5"; ph_cd = "R2 R5";
        load(v);
        ph_ab = "R4"; ph_cd = "R4";
        tick(100);
        pd = 1'b1; tick(100);                        // R8 A and C stop, R9 one PLL request
        alt = 1'b1; tick(40);
        pd = 1'b0; alt = 1'b0; tick(60);

        oe = 1'b0; tick(30);                         // R11 pads released
        oe = 1'b1; tick(20);

        v[66:60] = 7'h7f;
        load(v);
        pd = 1'b1; tick(30);                         // R10 oscillator request
        pd = 1'b0; tick(20);

        chk_on = 1'b0;
        rst = 1'b1; tick(2);
        rst = 1'b0; chk_on = 1'b1;
        ph_ab = "R1"; ph_cd = "R1";
        tick(30);
        chk_on = 1'b0;
        finish_run();
    end
endmodule